// File: doc/BRIEF.md
# FPGA Configuration Phase Controller

This block sits on a simple register bus and drives the configuration pins of an attached programmable-logic fabric. Software enables pin drive, asserts the active-low chip enable, and pulses a pull bit that holds the fabric in reset. The controller then tracks the fabric through its configuration phases. It uses the pull bit, the synchronised done and status lines from the fabric, and its own count of extra configuration clocks. Software reads the current phase and the sampled mode-select straps from a status register.

The fabric's monitor lines pass through a synchroniser. Any change on a synchronised line sets a sticky interrupt bit. Software clears these bits by writing ones to an end-of-interrupt register. Bitstream data transfer and configuration clock generation are handled elsewhere. The data-path enable and width bits are only held and driven out.

Top module: `cfg_phase_ctrl`

## Requirements
- R1: After reset the phase field reads 0, the control register reads 0x002, the interrupt status reads 0, `cfg_nconfig` is 1 and `irq` is 0.
- R2: Register 0 (status) returns the phase in bits [2:0] and the mode-select straps in bits [7:3]; all other bits read 0. Phase codes are off=0, reset=1, configure=2, initialise=3, user=4, unknown=5, and no other code ever appears.
- R3: Register 1 (control) holds five bits: bit 0 pin drive enable, bit 1 active-low chip enable, bit 2 pull-into-reset, bit 8 data-path enable and bit 9 32-bit width. Every other bit reads 0. The outputs `cfg_drive_en`, `cfg_nce`, `cfg_data_en` and `cfg_wide` follow these bits, and `cfg_nconfig` is low exactly while bits 0 and 2 are both set.
- R4: While control bit 0 is clear, the phase reads off.
- R5: With bit 0 set, bit 1 clear and bit 2 set, the phase becomes reset. Clearing bit 2 then moves it to configure. While bit 2 is set, the phase never goes to configure.
- R6: In configure, config-done seen high for 4 consecutive synchronised cycles moves the phase to initialise. 0x5000 further cycles then move it to user.
- R7: nSTATUS low in configure returns the phase to reset. The phase stays in reset until bit 2 has been set and cleared again.
- R8: Register 2 returns the monitor lines in bits [3:0] (bit 0 nSTATUS, bit 1 config-done, bit 2 init-done, bit 3 CRC error) after a two-flop synchroniser.
- R9: Any change on a synchronised monitor line sets the interrupt status bit of the same position in register 3. `irq` is the OR of those bits.
- R10: A write to register 3 clears each interrupt bit written with 1, so 0xFFF clears all of them. A new change in the same cycle wins over the clear.
- R11: nSTATUS low in initialise or user moves the phase to unknown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register index |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the address |
| strap_msel | input | 5 | Mode-select strap pins |
| mon_in | input | 4 | Fabric monitor lines (asynchronous) |
| cfg_drive_en | output | 1 | Controller drives configuration lines |
| cfg_nce | output | 1 | Active-low chip enable to the fabric |
| cfg_nconfig | output | 1 | Active-low reset request to the fabric |
| cfg_data_en | output | 1 | Bus configuration data accepted |
| cfg_wide | output | 1 | 32-bit data path selected |
| irq | output | 1 | Any monitor interrupt pending |

## Verification
The phase sequence is driven with a clean run from off to user, a run where nSTATUS falls during configure, and a run where it falls in user mode. These runs separate the normal path from the latched reset and the unknown outcome. Config-done is sampled both before and after the four-clock window, and the initialise phase is sampled before and after the long count, so that an early or late transition is caught. Interrupt clearing is tried with one bit, with a partial mask, and with the all-ones mask, which separates per-bit clearing from a global clear.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  typedef enum logic [2:0] {
    PH_OFF     = 3'd0,
    PH_RESET   = 3'd1,
    PH_CONFIG  = 3'd2,
    PH_INIT    = 3'd3,
    PH_USER    = 3'd4,
    PH_UNKNOWN = 3'd5
  } phase_t;

  localparam logic [1:0] A_STATUS = 2'd0;
  localparam logic [1:0] A_CTRL   = 2'd1;
  localparam logic [1:0] A_MON    = 2'd2;
  localparam logic [1:0] A_IRQ    = 2'd3;

  localparam int MON_NS = 0;
  localparam int MON_CD = 1;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/cfg_irq.sv
module cfg_irq #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lines,
  input  logic         clr_en,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] pending
);
  logic [W-1:0] prev;
  logic [W-1:0] chg;

  assign chg = lines ^ prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev    <= '0;
      pending <= '0;
    end else begin
      prev    <= lines;
      pending <= (pending & ~(clr_en ? clr_mask : '0)) | chg;
    end
  end

  // R10: full clear with no fresh change empties the status
  assert_eoi_clears_R10: assert property (@(posedge clk) disable iff (rst)
    (clr_en && (&clr_mask) && lines == prev) |=> pending == '0);
  // R9: a change always sets its bit
  assert_change_sets_R9: assert property (@(posedge clk) disable iff (rst)
    (lines[0] != prev[0]) |=> pending[0]);
endmodule

// File: rtl/cfg_phase_fsm.sv
module cfg_phase_fsm
  import cfg_pkg::*;
#(
  parameter int INIT_CLKS = 4,
  parameter int USER_CLKS = 20480
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   en,
  input  logic   nce,
  input  logic   pull,
  input  logic   ns,
  input  logic   cd,
  output phase_t phase
);
  localparam int CW = $clog2(USER_CLKS + INIT_CLKS + 1);

  logic [CW-1:0] cnt;
  logic          fault;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      phase <= PH_OFF;
      cnt   <= '0;
      fault <= 1'b0;
    end else if (pull) begin
      if (phase != PH_OFF || !nce) phase <= PH_RESET;
      cnt   <= '0;
      fault <= 1'b0;
    end else begin
      case (phase)
        PH_RESET: if (!fault) phase <= PH_CONFIG;
        PH_CONFIG: begin
          if (!ns) begin
            phase <= PH_RESET;
            fault <= 1'b1;
            cnt   <= '0;
          end else if (cd) begin
            if (cnt == CW'(INIT_CLKS - 1)) begin
              phase <= PH_INIT;
              cnt   <= '0;
            end else cnt <= cnt + 1'b1;
          end else cnt <= '0;
        end
        PH_INIT: begin
          if (!ns) phase <= PH_UNKNOWN;
          else if (cnt == CW'(USER_CLKS - 1)) begin
            phase <= PH_USER;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        PH_USER: if (!ns) phase <= PH_UNKNOWN;
        default: ;
      endcase
    end
  end

  assert_off_when_disabled_R4: assert property (@(posedge clk) disable iff (rst)
    !en |=> phase == PH_OFF);
  assert_legal_code_R2: assert property (@(posedge clk) disable iff (rst)
    phase <= PH_UNKNOWN);
  assert_pull_blocks_config_R5: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_RESET && pull) |=> phase != PH_CONFIG);
  assert_nstatus_fault_R7: assert property (@(posedge clk) disable iff (rst)
    (en && !pull && phase == PH_CONFIG && !ns) |=> (phase == PH_RESET || phase == PH_OFF));
endmodule

// File: rtl/cfg_phase_ctrl.sv
module cfg_phase_ctrl
  import cfg_pkg::*;
#(
  parameter int MON_W     = 4,
  parameter int MSEL_W    = 5,
  parameter int INIT_CLKS = 4,
  parameter int USER_CLKS = 20480
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [4:0]  strap_msel,
  input  logic [3:0]  mon_in,
  output logic        cfg_drive_en,
  output logic        cfg_nce,
  output logic        cfg_nconfig,
  output logic        cfg_data_en,
  output logic        cfg_wide,
  output logic        irq
);
  localparam int STAT_W = 3 + MSEL_W;

  logic              c_en, c_nce, c_pull, c_data, c_wide;
  logic [MSEL_W-1:0] msel_q;
  logic [MON_W-1:0]  mon_s;
  logic [MON_W-1:0]  pend;
  phase_t            phase;
  logic              wr_ctrl, wr_eoi;

  assign wr_ctrl = bus_wr && bus_addr == A_CTRL;
  assign wr_eoi  = bus_wr && bus_addr == A_IRQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      {c_en, c_pull, c_data, c_wide} <= '0;
      c_nce  <= 1'b1;
      msel_q <= '0;
    end else begin
      msel_q <= strap_msel;
      if (wr_ctrl) begin
        c_en   <= bus_wdata[0];
        c_nce  <= bus_wdata[1];
        c_pull <= bus_wdata[2];
        c_data <= bus_wdata[8];
        c_wide <= bus_wdata[9];
      end
    end
  end

  cfg_sync #(.W(MON_W), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d(mon_in), .q(mon_s)
  );

  cfg_irq #(.W(MON_W)) u_irq (
    .clk(clk), .rst(rst), .lines(mon_s), .clr_en(wr_eoi),
    .clr_mask(bus_wdata[MON_W-1:0]), .pending(pend)
  );

  cfg_phase_fsm #(.INIT_CLKS(INIT_CLKS), .USER_CLKS(USER_CLKS)) u_fsm (
    .clk(clk), .rst(rst), .en(c_en), .nce(c_nce), .pull(c_pull),
    .ns(mon_s[MON_NS]), .cd(mon_s[MON_CD]), .phase(phase)
  );

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      case (bus_addr)
        A_STATUS: bus_rdata <= 32'({msel_q, (c_en ? phase : PH_OFF)});
        A_CTRL:   bus_rdata <= {22'd0, c_wide, c_data, 5'd0, c_pull, c_nce, c_en};
        A_MON:    bus_rdata <= 32'(mon_s);
        default:  bus_rdata <= 32'(pend);
      endcase
    end
  end

  assign cfg_drive_en = c_en;
  assign cfg_nce      = c_nce;
  assign cfg_nconfig  = !(c_en && c_pull);
  assign cfg_data_en  = c_data;
  assign cfg_wide     = c_wide;
  assign irq          = |pend;

  assert_status_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == A_STATUS) |=> bus_rdata[31:STAT_W] == '0);
  assert_nconfig_pull_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && bus_wdata[0] && bus_wdata[2]) |=> !cfg_nconfig);
endmodule

// File: tb/cfg_phase_ctrl_tb.sv
module cfg_phase_ctrl_tb;
  logic        clk = 0;
  logic        rst = 1;
  logic [1:0]  bus_addr = 0;
  logic        bus_wr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [4:0]  strap_msel = 5'h16;
  logic [3:0]  mon_in = 0;
  logic        cfg_drive_en, cfg_nce, cfg_nconfig, cfg_data_en, cfg_wide, irq;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  cfg_phase_ctrl u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .strap_msel(strap_msel),
    .mon_in(mon_in), .cfg_drive_en(cfg_drive_en), .cfg_nce(cfg_nce),
    .cfg_nconfig(cfg_nconfig), .cfg_data_en(cfg_data_en), .cfg_wide(cfg_wide),
    .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a;
    @(negedge clk); d = bus_rdata;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(0, v); chk("R1 phase off", v[2:0], 0);
    chk("R2 strap field", v, 32'hB0);
    rd(1, v); chk("R1 ctrl reset", v, 32'h2);
    rd(3, v); chk("R1 irq status", v, 0);
    chk("R1 nconfig", cfg_nconfig, 1);
    chk("R1 irq pin", irq, 0);
  endtask

  task automatic t_ctrl;
    logic [31:0] v;
    wr(1, 32'hFFFF_FFFF);
    rd(1, v); chk("R3 ctrl mask", v, 32'h307);
    chk("R3 pins", {cfg_drive_en, cfg_nce, cfg_nconfig, cfg_data_en, cfg_wide}, 5'b11011);
    wr(1, 32'h4); waitc(3);
    rd(0, v); chk("R4 off when disabled", v[2:0], 0);
    chk("R3 nconfig high without drive", cfg_nconfig, 1);
  endtask

  task automatic t_mon_irq;
    logic [31:0] v;
    mon_in = 4'b0001; waitc(5);
    rd(2, v); chk("R8 synced monitor", v, 1);
    rd(3, v); chk("R9 nstatus change", v, 1);
    chk("R9 irq pin", irq, 1);
    wr(3, 1); rd(3, v); chk("R10 single clear", v, 0);
    mon_in = 4'b1101; waitc(5);
    rd(3, v); chk("R9 crc and init-done", v, 32'hC);
    wr(3, 4); rd(3, v); chk("R10 partial clear", v, 32'h8);
    wr(3, 32'hFFF); rd(3, v); chk("R10 full clear", v, 0);
    chk("R10 irq pin low", irq, 0);
    mon_in = 4'b0001; waitc(5); wr(3, 32'hFFF);
  endtask

  task automatic t_seq;
    logic [31:0] v;
    wr(1, 32'h5); waitc(2);
    rd(0, v); chk("R5 reset phase", v[2:0], 1);
    chk("R5 nconfig low", cfg_nconfig, 0);
    wr(1, 32'h1); waitc(2);
    rd(0, v); chk("R5 configure phase", v[2:0], 2);
    mon_in = 4'b0000; waitc(5);
    rd(0, v); chk("R7 fault to reset", v[2:0], 1);
    mon_in = 4'b0001; waitc(10);
    rd(0, v); chk("R7 stays in reset", v[2:0], 1);
    wr(1, 32'h5); wr(1, 32'h1); waitc(2);
    rd(0, v); chk("R7 reconfigure after toggle", v[2:0], 2);
    wr(1, 32'h101);
    mon_in = 4'b0011; waitc(1);
    rd(0, v); chk("R6 still configure early", v[2:0], 2);
    waitc(10);
    rd(0, v); chk("R6 initialise", v[2:0], 3);
    waitc(20000);
    rd(0, v); chk("R6 initialise before count", v[2:0], 3);
    waitc(1000);
    rd(0, v); chk("R6 user mode", v[2:0], 4);
    mon_in = 4'b0010; waitc(5);
    rd(0, v); chk("R11 unknown", v[2:0], 5);
    wr(1, 0); waitc(2);
    rd(0, v); chk("R4 disable to off", v[2:0], 0);
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        rst = 0;
        t_reset();
        t_ctrl();
        t_mon_irq();
        t_seq();
      end
      begin
        repeat (100000) @(negedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule